// File: doc/BRIEF.md
# Ticket-Based Register Semaphore

This block guards a shared access gateway that several host agents reach through one 32-bit register window. Two registers matter. The ticket register returns a fresh nonzero value each time it is read. The lock register reads as zero while the gateway is free, and it holds the owner's ticket while the gateway is taken.

An agent takes the lock in three steps. It reads a ticket. It writes that ticket into the lock register. It then reads the lock register back. The agent owns the gateway only if the read-back value equals its own ticket. When two agents race, only the first nonzero write lands; every later nonzero write is dropped until the lock is freed. Writing zero to the lock register frees it. The retry policy is left to the host: an agent that finds the lock held keeps polling, up to 2048 attempts.

Reads are registered. The data and a valid strobe appear one clock after the read request. The reset is synchronous and active high.

Top module: `ticket_semaphore`

## Requirements
- R1: After reset, `rd_valid` and `rd_data` are 0, the lock register reads 0 and the first ticket read returns 1.
- R2: A read at byte offset 0x08 returns the current ticket, zero-extended to DATA_W bits, in `rd_data` one clock after the request.
- R3: Each ticket read advances the ticket by one, so consecutive ticket reads return different values. No other access changes the ticket.
- R4: The ticket never takes the value 0. After the all-ones value of TICKET_W bits, the next ticket is 1.
- R5: A nonzero write at byte offset 0x0C while the lock holds 0 stores the written value. A later read at 0x0C returns that value.
- R6: A nonzero write at 0x0C while the lock holds a nonzero value is ignored, and the held value is kept.
- R7: A write of 0 at 0x0C always frees the lock, whatever value it held.
- R8: Reads at 0x0C change neither the lock value nor the ticket.
- R9: A read at any offset other than 0x08 and 0x0C, including unaligned offsets, returns 0. A write at any offset other than 0x0C, including the ticket offset, has no effect.
- R10: When a read and a write arrive in the same cycle, the read returns the value from before the write.
- R11: `rd_valid` is high in exactly the cycle after each cycle with `rd_en` high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read request for the offset on `addr` |
| wr_en | input | 1 | Write request for the offset on `addr` |
| addr | input | ADDR_W | Byte offset within the window |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| rd_valid | output | 1 | High one cycle after a read request |

## Verification
The bench builds the block with TICKET_W set to 4, so the ticket wraps from 15 back to 1 within a few dozen reads, and the zero-skip rule can be checked directly. DATA_W stays at 32 and ADDR_W at 8. With these values, the full lock value, the unaligned offsets and the unmapped offsets are all exercised. A two-agent race model runs the write order both ways, and random mixes of ticket reads, lock writes and stray accesses are compared against a bench model of the ticket and the lock.

// File: rtl/tsem_pkg.sv
package tsem_pkg;

  localparam int unsigned OFS_TICKET = 32'h08;
  localparam int unsigned OFS_LOCK   = 32'h0C;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_TICKET = 2'd1,
    SEL_LOCK   = 2'd2
  } reg_sel_e;

endpackage

// File: rtl/tsem_decode.sv
module tsem_decode
  import tsem_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  localparam logic [ADDR_W-1:0] A_TICKET = ADDR_W'(OFS_TICKET);
  localparam logic [ADDR_W-1:0] A_LOCK   = ADDR_W'(OFS_LOCK);

  always_comb begin
    if (addr == A_TICKET)    sel = SEL_TICKET;
    else if (addr == A_LOCK) sel = SEL_LOCK;
    else                     sel = SEL_NONE;
  end

endmodule

// File: rtl/tsem_ticket_ctr.sv
module tsem_ticket_ctr #(
  parameter int TICKET_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                advance,
  output logic [TICKET_W-1:0] ticket_q
);

  localparam logic [TICKET_W-1:0] T_FIRST = TICKET_W'(1);
  localparam logic [TICKET_W-1:0] T_LAST  = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ticket_q <= T_FIRST;
    end else if (advance) begin
      // zero is the free marker, so the wrap lands on one
      ticket_q <= (ticket_q == T_LAST) ? T_FIRST : ticket_q + T_FIRST;
    end
  end

endmodule

// File: rtl/tsem_lock_reg.sv
module tsem_lock_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] owner_q
);

  logic free_now;
  logic release_req;

  assign free_now    = (owner_q == '0);
  assign release_req = (wdata == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q <= '0;
    end else if (wr && (release_req || free_now)) begin
      owner_q <= wdata;
    end
  end

endmodule

// File: rtl/ticket_semaphore.sv
module ticket_semaphore
  import tsem_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int TICKET_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  reg_sel_e            sel;
  logic [TICKET_W-1:0] ticket_q;
  logic [DATA_W-1:0]   owner_q;
  logic [DATA_W-1:0]   ticket_ext;
  logic [DATA_W-1:0]   rd_mux;

  tsem_decode #(.ADDR_W(ADDR_W)) dec_i (
    .addr (addr),
    .sel  (sel)
  );

  tsem_ticket_ctr #(.TICKET_W(TICKET_W)) ctr_i (
    .clk      (clk),
    .rst      (rst),
    .advance  (rd_en && (sel == SEL_TICKET)),
    .ticket_q (ticket_q)
  );

  tsem_lock_reg #(.DATA_W(DATA_W)) lock_i (
    .clk     (clk),
    .rst     (rst),
    .wr      (wr_en && (sel == SEL_LOCK)),
    .wdata   (wr_data),
    .owner_q (owner_q)
  );

  generate
    if (TICKET_W < DATA_W) begin : g_pad
      assign ticket_ext = {{(DATA_W-TICKET_W){1'b0}}, ticket_q};
    end else begin : g_full
      assign ticket_ext = ticket_q[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    case (sel)
      SEL_TICKET: rd_mux = ticket_ext;
      SEL_LOCK:   rd_mux = owner_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

endmodule

// File: rtl/tsem_checker.sv
module tsem_checker
  import tsem_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int TICKET_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                rd_en,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   addr,
  input logic [DATA_W-1:0]   wr_data,
  input logic                rd_valid,
  input logic [TICKET_W-1:0] ticket_q,
  input logic [DATA_W-1:0]   owner_q
);

  logic tick_rd, lock_wr;
  assign tick_rd = rd_en && (addr == ADDR_W'(OFS_TICKET));
  assign lock_wr = wr_en && (addr == ADDR_W'(OFS_LOCK));

  p_ticket_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
    ticket_q != '0);

  p_ticket_moves_r3: assert property (@(posedge clk) disable iff (rst)
    tick_rd |=> ticket_q != $past(ticket_q));

  p_ticket_still_r3: assert property (@(posedge clk) disable iff (rst)
    !tick_rd |=> $stable(ticket_q));

  p_held_kept_r6: assert property (@(posedge clk) disable iff (rst)
    (lock_wr && owner_q != '0 && wr_data != '0) |=> $stable(owner_q));

  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    (lock_wr && wr_data == '0) |=> owner_q == '0);

  p_take_r5: assert property (@(posedge clk) disable iff (rst)
    (lock_wr && owner_q == '0) |=> owner_q == $past(wr_data));

  p_untouched_r9: assert property (@(posedge clk) disable iff (rst)
    !lock_wr |=> $stable(owner_q));

  p_valid_on_r11: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  p_valid_off_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

endmodule

bind ticket_semaphore tsem_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TICKET_W(TICKET_W)
) chk_i (
  .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .wr_data(wr_data), .rd_valid(rd_valid), .ticket_q(ticket_q),
  .owner_q(owner_q)
);

// File: tb/ticket_semaphore_tb_top.sv
module ticket_semaphore_tb_top;

  localparam int DW = 32;
  localparam int AW = 8;
  localparam int TW = 4;
  localparam logic [AW-1:0] A_TK = 8'h08;
  localparam logic [AW-1:0] A_LK = 8'h0C;
  localparam logic [DW-1:0] T_MAX = (1 << TW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd_en = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          rd_valid;

  int vectors = 0;
  int misses  = 0;
  logic [DW-1:0] m_ticket;
  logic [DW-1:0] m_lock;

  always #4 clk = ~clk;

  ticket_semaphore #(.DATA_W(DW), .ADDR_W(AW), .TICKET_W(TW)) dut_i (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  function automatic logic [DW-1:0] ticket_after(logic [DW-1:0] t);
    return (t == T_MAX) ? 1 : t + 1;
  endfunction

  function automatic logic [DW-1:0] lock_after(logic [DW-1:0] cur, logic [DW-1:0] w);
    if (w == 0) return 0;
    return (cur == 0) ? w : cur;
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one-cycle read; data sampled at the following falling edge
  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
    check("R11 valid", {31'b0, rd_valid}, 1);
    if (a == A_TK) m_ticket = ticket_after(m_ticket);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == A_LK) m_lock = lock_after(m_lock, d);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    misses++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] d, ta, tb, ra, rb;
    void'($urandom(32'd20240611));
    m_ticket = 1; m_lock = 0;
    repeat (3) @(negedge clk);
    check("R1 valid", {31'b0, rd_valid}, 0);
    check("R1 data", rd_data, 0);
    rst = 1'b0;
    rd(A_LK, d); check("R1 lock", d, 0);
    rd(A_TK, d); check("R1 first ticket", d, 1);
    @(negedge clk);
    check("R11 idle", {31'b0, rd_valid}, 0);

    // R2 / R3: successive tickets
    for (int i = 0; i < 3; i++) begin
      logic [DW-1:0] e; e = m_ticket;
      rd(A_TK, d); check("R2 R3 ticket", d, e);
    end
    // R4: wrap skips zero
    for (int i = 0; i < 20; i++) begin
      logic [DW-1:0] e; e = m_ticket;
      rd(A_TK, d); check("R4 wrap", d, e);
      if (d == 0) check("R4 nonzero", d, 1);
    end
    // R8: lock reads leave both registers alone
    ta = m_ticket;
    for (int i = 0; i < 3; i++) begin rd(A_LK, d); check("R8 lock read", d, 0); end
    rd(A_TK, d); check("R8 ticket kept", d, ta);
    // R5 R6 R7
    wr(A_LK, 5); rd(A_LK, d); check("R5 take", d, 5);
    wr(A_LK, 9); rd(A_LK, d); check("R6 ignored", d, 5);
    wr(A_LK, 0); rd(A_LK, d); check("R7 free", d, 0);
    wr(A_LK, 32'hFFFF_FFFF); wr(A_LK, 0); rd(A_LK, d); check("R7 free all-ones", d, 0);
    // R9: stray offsets
    rd(8'h04, d); check("R9 unmapped", d, 0);
    rd(8'h0D, d); check("R9 unaligned", d, 0);
    wr(8'h0D, 7); rd(A_LK, d); check("R9 stray write", d, 0);
    ta = m_ticket;
    wr(A_TK, 32'h3); rd(A_TK, d); check("R9 ticket write", d, ta);
    // R10: read and write together
    @(negedge clk);
    rd_en = 1'b1; wr_en = 1'b1; addr = A_LK; wr_data = 32'hA;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    check("R10 old value", rd_data, 0);
    m_lock = lock_after(m_lock, 32'hA);
    rd(A_LK, d); check("R10 new value", d, 32'hA);
    wr(A_LK, 0);

    // two-agent race: the first writer wins, the other retries
    for (int r = 0; r < 40; r++) begin
      bit a_first;
      int tries;
      a_first = $urandom_range(0, 1) == 1;
      rd(A_TK, ta); rd(A_TK, tb);
      rd(A_LK, d); check("R5 race free", d, 0);
      if (a_first) begin wr(A_LK, ta); wr(A_LK, tb); end
      else         begin wr(A_LK, tb); wr(A_LK, ta); end
      rd(A_LK, ra); rd(A_LK, rb);
      check("R6 one winner", {31'b0, (ra == ta) ^ (rb == tb)}, 1);
      check("R6 first wins", ra, a_first ? ta : tb);
      wr(A_LK, 0);
      tries = 0;
      d = 1;
      while (d != 0 && tries < 2048) begin rd(A_LK, d); tries++; end
      rd(A_TK, tb); wr(A_LK, tb); rd(A_LK, rb);
      check("R5 loser retries", rb, tb);
      wr(A_LK, 0);
    end

    // random mix against the model
    for (int i = 0; i < 400; i++) begin
      int op; logic [DW-1:0] e;
      op = $urandom_range(0, 4);
      case (op)
        0: begin e = m_ticket; rd(A_TK, d); check("R3 random ticket", d, e); end
        1: begin e = m_lock; rd(A_LK, d); check("R5 random lock", d, e); end
        2: wr(A_LK, ($urandom_range(0, 2) == 0) ? 0 : ($urandom() | 1));
        3: begin rd(AW'($urandom_range(0, 7) * 2 + 16), d); check("R9 random stray", d, 0); end
        default: wr(AW'($urandom_range(16, 255)), $urandom());
      endcase
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule